// File: doc/BRIEF.md
# Per-Channel Audio Zero-Data Detector

This block watches a stereo stream of signed audio samples, one word per channel per frame strobe, and raises a flag for each channel once that channel has carried nothing but all-zero words for a long, unbroken run of frames. A downstream stage can use the flags to mute or power down an idle output path. The flag falls as soon as any nonzero word shows up on its channel.

A few control bits shape the outputs. A detect enable turns detection off and holds both flags deasserted. A merge bit ties the channels together so that both flags rise only when both channels are silent. A polarity bit inverts both outputs. An active-low soft-run bit forces both flags asserted while it is low, and releases them a fixed number of frames after it returns high. All run counting and release timing advance only on the frame strobe. The control bits act on the outputs combinationally.

Top module: `zero_run_flagger`

## Requirements
- R1: With defaults (RUN_LEN = 8192), a channel's flag asserts in the clock after the strobe that delivers the 8192nd consecutive all-zero sample on that channel. After 8191 such samples it is still deasserted.
- R2: A strobe that delivers a nonzero sample deasserts that channel's flag in the following clock. The run then starts again from zero.
- R3: While run_n is 0, both flags are asserted, whatever the sample data is.
- R4: After run_n returns to 1, both flags stay asserted through the first strobe. They deassert after the second strobe (RELEASE_FRAMES = 2) unless a channel's own run qualifies.
- R5: With merge_mode = 1, both flags assert only when both channels have each completed a qualifying zero run. A silent channel paired with a busy one yields two deasserted flags.
- R6: With det_enable = 0, both flags are deasserted, and this overrides R3.
- R7: invert_out = 1 inverts both flag outputs. The inversion is applied after the enable, soft-run and merge logic, so a disabled detector then drives 1.
- R8: A sample counts as zero only if all SAMPLE_W bits are 0, so a word with only the LSB (24'h000001) or only the sign bit (24'h800000) set counts as nonzero. Each channel counts only its own samples.
- R9: The run count saturates at RUN_LEN. A zero run of 16384 frames leaves the flag asserted.
- R10: With rst_n low, the run counts and the release counter are cleared. After rst_n rises with run_n = 1 and det_enable = 1, both flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| frame_stb | input | 1 | One-clock pulse per frame; samples are taken on it |
| sample_l | input | SAMPLE_W | Left-channel sample word |
| sample_r | input | SAMPLE_W | Right-channel sample word |
| det_enable | input | 1 | 1 enables detection; 0 holds flags deasserted |
| merge_mode | input | 1 | 1 requires both channels silent for either flag |
| invert_out | input | 1 | 1 inverts both flag outputs |
| run_n | input | 1 | Soft reset, active low; 0 forces flags asserted |
| flag_l | output | 1 | Left-channel zero-run flag |
| flag_r | output | 1 | Right-channel zero-run flag |

## Verification
On every cycle, the assertions check that the counts step by one on a zero strobe, clear on a nonzero strobe and never pass the threshold. They also check that the release counter stays in range, that a disabled or soft-reset detector drives the right levels, and that merged flags always agree. Only the bench's scenarios can show the exact frame on which a flag rises after a full run, the two-frame release after the soft reset, and that a silent channel next to a busy one stays low in merge mode yet would be high in split mode. The same holds for the outcome of runs long enough to wrap an unsaturated counter.

// File: rtl/zero_run_flagger.sv
module zero_run_flagger #(
  parameter int SAMPLE_W       = 24,
  parameter int RUN_LEN        = 8192,
  parameter int RELEASE_FRAMES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_stb,
  input  logic [SAMPLE_W-1:0] sample_l,
  input  logic [SAMPLE_W-1:0] sample_r,
  input  logic                det_enable,
  input  logic                merge_mode,
  input  logic                invert_out,
  input  logic                run_n,
  output logic                flag_l,
  output logic                flag_r
);

  localparam int CW = $clog2(RUN_LEN + 1);
  localparam int RW = $clog2(RELEASE_FRAMES + 1);
  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);
  localparam logic [RW-1:0] REL_INIT = RW'(RELEASE_FRAMES);

  logic [SAMPLE_W-1:0] smp [2];
  logic [CW-1:0]       run_cnt [2];
  logic [1:0]          sat;
  logic [RW-1:0]       rel_cnt;
  logic                hold;
  logic                both;
  logic                act_l, act_r;

  assign smp[0] = sample_l;
  assign smp[1] = sample_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int ch = 0; ch < 2; ch++) run_cnt[ch] <= '0;
    end else if (frame_stb) begin
      for (int ch = 0; ch < 2; ch++) begin
        if (!run_n || smp[ch] != '0) run_cnt[ch] <= '0;
        else if (run_cnt[ch] != FULL) run_cnt[ch] <= run_cnt[ch] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            rel_cnt <= '0;
    else if (!run_n)                       rel_cnt <= REL_INIT;
    else if (frame_stb && rel_cnt != '0)   rel_cnt <= rel_cnt - 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_sat
      assign sat[g] = (run_cnt[g] == FULL);
    end
  endgenerate

  assign hold  = !run_n || (rel_cnt != '0);
  assign both  = &sat;
  assign act_l = det_enable && (hold || (merge_mode ? both : sat[0]));
  assign act_r = det_enable && (hold || (merge_mode ? both : sat[1]));
  assign flag_l = act_l ^ invert_out;
  assign flag_r = act_r ^ invert_out;

  AST_STEP_L: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && run_n && sample_l == '0 && run_cnt[0] != FULL |=> run_cnt[0] == $past(run_cnt[0]) + 1'b1); // R1
  AST_STEP_R: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && run_n && sample_r == '0 && run_cnt[1] != FULL |=> run_cnt[1] == $past(run_cnt[1]) + 1'b1); // R1
  AST_NONZERO_CLEARS_L: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && sample_l != '0 |=> run_cnt[0] == '0); // R2
  AST_NONZERO_CLEARS_R: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb && sample_r != '0 |=> run_cnt[1] == '0); // R2
  AST_SOFT_RESET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    det_enable && !run_n |-> flag_l == !invert_out && flag_r == !invert_out); // R3
  AST_RELEASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_cnt <= REL_INIT); // R4
  AST_MERGE_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    merge_mode |-> flag_l == flag_r); // R5
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !det_enable |-> flag_l == invert_out && flag_r == invert_out); // R6
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt[0] <= FULL && run_cnt[1] <= FULL); // R9
  AST_HOLD_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    run_n && run_cnt[0] == FULL && !(frame_stb && sample_l != '0) |=> run_cnt[0] == FULL); // R9

endmodule

// File: tb/zero_run_flagger_test.sv
module zero_run_flagger_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        frame_stb = 0;
  logic [23:0] sample_l = '0;
  logic [23:0] sample_r = '0;
  logic        det_enable = 1;
  logic        merge_mode = 0;
  logic        invert_out = 0;
  logic        run_n = 1;
  logic        flag_l, flag_r;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  zero_run_flagger uut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .sample_l(sample_l), .sample_r(sample_r),
    .det_enable(det_enable), .merge_mode(merge_mode),
    .invert_out(invert_out), .run_n(run_n),
    .flag_l(flag_l), .flag_r(flag_r)
  );

  task automatic chk(input string req, input logic [1:0] exp);
    n_checks++;
    if ({flag_l, flag_r} !== exp) begin
      n_fail++;
      $display("FAIL %s: flags {l,r} = %b, expected %b", req, {flag_l, flag_r}, exp);
    end
  endtask

  task automatic frame(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    sample_l = l; sample_r = r; frame_stb = 1;
    @(negedge clk);
    frame_stb = 0;
  endtask

  task automatic frames(input int n, input logic [23:0] l, input logic [23:0] r);
    for (int i = 0; i < n; i++) frame(l, r);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset state", 2'b00);
  endtask

  task automatic t_single_run;
    frames(8191, 24'h0, 24'h1);
    chk("R1 after 8191 zeros", 2'b00);
    frame(24'h0, 24'h1);
    chk("R1 R8 after 8192 zeros, right busy", 2'b10);
  endtask

  task automatic t_lsb_breaks;
    frame(24'h000001, 24'h1);
    chk("R2 R8 LSB-only word clears", 2'b00);
    frame(24'h0, 24'h1);
    chk("R2 run restarted", 2'b00);
  endtask

  task automatic t_soft_reset;
    @(negedge clk); run_n = 0;
    @(negedge clk);
    chk("R3 forced high", 2'b11);
    frames(3, 24'h123, 24'h456);
    chk("R3 held with busy data", 2'b11);
    run_n = 1;
    @(negedge clk);
    chk("R4 still high right after release", 2'b11);
    frame(24'h7, 24'h7);
    chk("R4 high after first strobe", 2'b11);
    frame(24'h7, 24'h7);
    chk("R4 low after second strobe", 2'b00);
  endtask

  task automatic t_merge_and_controls;
    merge_mode = 1;
    frames(8192, 24'h0, 24'h5);
    chk("R5 merged, right busy", 2'b00);
    merge_mode = 0;
    @(negedge clk);
    chk("R5 split view of same state", 2'b10);
    merge_mode = 1;
    frames(8191, 24'h0, 24'h0);
    chk("R5 right one short", 2'b00);
    frame(24'h0, 24'h0);
    chk("R5 R9 both complete, left ran 16384", 2'b11);
    det_enable = 0;
    @(negedge clk);
    chk("R6 disabled while saturated", 2'b00);
    invert_out = 1;
    @(negedge clk);
    chk("R7 disabled and inverted", 2'b11);
    det_enable = 1;
    @(negedge clk);
    chk("R7 detected and inverted", 2'b00);
    invert_out = 0;
    frame(24'h0, 24'h800000);
    chk("R2 R5 R8 sign-bit word clears both", 2'b00);
    merge_mode = 0;
    @(negedge clk);
    chk("R8 left still saturated in split mode", 2'b10);
  endtask

  task automatic t_disable_over_reset;
    det_enable = 0; run_n = 0;
    @(negedge clk);
    chk("R6 enable off overrides soft reset", 2'b00);
    invert_out = 1;
    @(negedge clk);
    chk("R7 inversion after override", 2'b11);
    invert_out = 0; run_n = 1; det_enable = 1;
    frames(2, 24'h9, 24'h9);
    chk("R4 released after override test", 2'b00);
  endtask

  initial begin
    t_reset();
    t_single_run();
    t_lsb_breaks();
    t_soft_reset();
    t_merge_and_controls();
    t_disable_over_reset();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule